// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture Controller

This block sits on the inbound memory-write path of a host bridge and turns message-signalled interrupts into level interrupt requests. Each inbound write is compared against a programmed 64-bit target address and a masked data pattern. A write that matches sets one of 32 pending bits, chosen by the low five bits of the write data. Software sees the pending bits through a read-only status register. It acknowledges them through a write-one-to-clear register and gates them through a mask that has separate set and clear ports. The block drives one combined interrupt line.

Bit 0 of the low target word is the enable, not an address bit. The data-config register holds a compare mask in its upper half and the expected pattern in its lower half. Its value after reset accepts data words whose upper bits read 0x6540, with the vector number ORed into bits 4:0.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset the status register (offset 0) reads 0, the mask (offsets 2 and 3) reads 0xFFFFFFFF, both target words (offsets 4 and 5) read 0, data-config (offset 6) reads 0xFFE06540, and `irqOut` is low.
- R2: An inbound write is captured when it meets all three conditions: enable bit 0 of offset 4 is set, `inWrAddr[63:2]` equals {offset 5, offset 4 bits 31:2}, and (`inWrData[15:0]` AND data-config[31:16]) equals data-config[15:0]. A captured write sets status bit `inWrData[4:0]`, and that bit is visible on the clock edge after the write cycle.
- R3: While bit 0 of offset 4 is 0, no inbound write changes the status register.
- R4: `inWrAddr[1:0]` do not affect matching. A write whose address differs from the target in any of bits 63:2 leaves status unchanged.
- R5: A write whose masked data differs from the pattern leaves status unchanged. `inWrData[31:16]` do not affect matching.
- R6: Writing offset 1 clears each status bit whose data bit is 1 and leaves bits written 0 unchanged. Offset 1 reads 0.
- R7: Writing offset 2 sets the mask bits given as 1. Writing offset 3 clears the mask bits given as 1. The current mask reads back at both offsets.
- R8: `irqOut` is high exactly when some status bit is set whose mask bit is 0. A masked vector still records its status bit.
- R9: When a capture and a clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Writes to offset 0 are ignored. Offset 7 reads 0. Offsets 4, 5 and 6 read back the full value last written, including the enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inWrValid | input | 1 | Inbound memory write present this cycle |
| inWrAddr | input | 64 | Inbound write byte address |
| inWrData | input | 32 | Inbound write data |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register word offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The hardest situation to reach from the ports is a capture and a software clear that land on the same status bit in the same clock cycle, because the two arrive on unrelated ports. A dedicated task drives both in one cycle and reads the bit back afterwards. A bench that issues these accesses one after another never produces this case. Rejection of near-miss writes also needs its own stimulus: a separate write is sent for each of these cases, namely a wrong high address word, a wrong low word, only bits 1:0 changed, a pattern error, and differing upper data bits, and status is read after each one.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int VEC_CNT = 32;
  localparam int VEC_W   = $clog2(VEC_CNT);
  localparam int REG_W   = 32;
  localparam int HALF_W  = REG_W / 2;
  localparam int REG_AW  = 3;
  localparam int ADDR_W  = 2 * REG_W;
  localparam logic [REG_W-1:0] DCFG_RESET = 32'hffe06540;

  typedef enum logic [REG_AW-1:0] {
    REG_STATUS = 3'd0,
    REG_CLEAR  = 3'd1,
    REG_MSET   = 3'd2,
    REG_MCLR   = 3'd3,
    REG_TGT_LO = 3'd4,
    REG_TGT_HI = 3'd5,
    REG_DCFG   = 3'd6,
    REG_NONE   = 3'd7
  } regSel_e;

  typedef struct packed {
    logic               capValid;
    logic [VEC_CNT-1:0] capBits;
    logic [VEC_CNT-1:0] clrBits;
    logic [VEC_CNT-1:0] maskSetBits;
    logic [VEC_CNT-1:0] maskClrBits;
    logic               tgtLoWr;
    logic               tgtHiWr;
    logic               cfgWr;
    logic [REG_W-1:0]   wrData;
  } strobes_t;
endpackage

// File: rtl/msi_cap_ctrl.sv
module msi_cap_ctrl
  import msi_cap_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inWrValid,
  input  logic [ADDR_W-1:0]      inWrAddr,
  input  logic [REG_W-1:0]       inWrData,
  input  logic                   regWrEn,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [REG_W-1:0]       regWrData,
  input  logic [REG_W-1:0]       tgtLo,
  input  logic [REG_W-1:0]       tgtHi,
  input  logic [REG_W-1:0]       dataCfg,
  output strobes_t               strobes
);
  logic msiEn, addrHit, patHit, capHit;
  logic [VEC_W-1:0] vecIdx;
  logic [VEC_CNT-1:0] capOneHot;
  logic [VEC_CNT-1:0] wrVec;
  regSel_e wrSel;

  // Inbound match: enable, address with byte bits ignored, masked data pattern
  assign msiEn   = tgtLo[0];
  assign addrHit = (inWrAddr[ADDR_W-1:2] == {tgtHi, tgtLo[REG_W-1:2]});
  assign patHit  = ((inWrData[HALF_W-1:0] & dataCfg[REG_W-1:HALF_W]) == dataCfg[HALF_W-1:0]);
  assign capHit  = inWrValid && msiEn && addrHit && patHit;
  assign vecIdx  = inWrData[VEC_W-1:0];

  for (genvar v = 0; v < VEC_CNT; v++) begin : g_vecDec
    assign capOneHot[v] = capHit && (vecIdx == VEC_W'(v));
  end

  assign wrSel = regSel_e'(regAddr);
  assign wrVec = regWrData[VEC_CNT-1:0];

  always_comb begin
    strobes = '0;
    strobes.capValid = capHit;
    strobes.capBits  = capOneHot;
    strobes.wrData   = regWrData;
    if (regWrEn) begin
      unique case (wrSel)
        REG_CLEAR:  strobes.clrBits     = wrVec;
        REG_MSET:   strobes.maskSetBits = wrVec;
        REG_MCLR:   strobes.maskClrBits = wrVec;
        REG_TGT_LO: strobes.tgtLoWr     = 1'b1;
        REG_TGT_HI: strobes.tgtHiWr     = 1'b1;
        REG_DCFG:   strobes.cfgWr       = 1'b1;
        default: ;
      endcase
    end
  end

  // R2
  cap_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capValid |-> ($countones(strobes.capBits) == 1));

  // R7
  mask_strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strobes.maskSetBits & strobes.maskClrBits) == '0));
endmodule

// File: rtl/msi_cap_dp.sv
module msi_cap_dp
  import msi_cap_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [REG_AW-1:0]  regAddr,
  output logic [REG_W-1:0]   regRdData,
  output logic [REG_W-1:0]   tgtLo,
  output logic [REG_W-1:0]   tgtHi,
  output logic [REG_W-1:0]   dataCfg,
  output logic               irqOut
);
  logic [VEC_CNT-1:0] status, mask;
  logic [VEC_CNT-1:0] capMasked;
  regSel_e rdSel;

  assign capMasked = strobes.capValid ? strobes.capBits : '0;

  // Per-vector pending and mask cells; capture dominates clear
  for (genvar v = 0; v < VEC_CNT; v++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rstN) begin
        status[v] <= 1'b0;
        mask[v]   <= 1'b1;
      end else begin
        if (capMasked[v])              status[v] <= 1'b1;
        else if (strobes.clrBits[v])   status[v] <= 1'b0;
        if (strobes.maskSetBits[v])      mask[v] <= 1'b1;
        else if (strobes.maskClrBits[v]) mask[v] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tgtLo   <= '0;
      tgtHi   <= '0;
      dataCfg <= DCFG_RESET;
    end else begin
      if (strobes.tgtLoWr) tgtLo   <= strobes.wrData;
      if (strobes.tgtHiWr) tgtHi   <= strobes.wrData;
      if (strobes.cfgWr)   dataCfg <= strobes.wrData;
    end
  end

  assign irqOut = |(status & ~mask);

  assign rdSel = regSel_e'(regAddr);
  always_comb begin
    regRdData = '0;
    unique case (rdSel)
      REG_STATUS:         regRdData = REG_W'(status);
      REG_MSET, REG_MCLR: regRdData = REG_W'(mask);
      REG_TGT_LO:         regRdData = tgtLo;
      REG_TGT_HI:         regRdData = tgtHi;
      REG_DCFG:           regRdData = dataCfg;
      default:            regRdData = '0;
    endcase
  end

  // R9
  cap_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capValid |=> ((status & $past(strobes.capBits)) == $past(strobes.capBits)));

  // R6
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrBits != '0) |=> ((status & $past(strobes.clrBits & ~capMasked)) == '0));

  // R3
  no_cap_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tgtLo[0] |=> ((status & ~$past(status)) == '0));

  // R7
  mask_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.maskSetBits != '0) |=> ((mask & $past(strobes.maskSetBits)) == $past(strobes.maskSetBits)));

  // R8
  all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&mask) |-> !irqOut);
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inWrValid,
  input  logic [63:0]       inWrAddr,
  input  logic [31:0]       inWrData,
  input  logic              regWrEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              irqOut
);
  strobes_t strobes;
  logic [REG_W-1:0] tgtLo, tgtHi, dataCfg;

  msi_cap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .inWrValid(inWrValid), .inWrAddr(inWrAddr), .inWrData(inWrData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .tgtLo(tgtLo), .tgtHi(tgtHi), .dataCfg(dataCfg),
    .strobes(strobes)
  );

  msi_cap_dp u_dp (
    .clk(clk), .rstN(rstN),
    .strobes(strobes), .regAddr(regAddr),
    .regRdData(regRdData),
    .tgtLo(tgtLo), .tgtHi(tgtHi), .dataCfg(dataCfg),
    .irqOut(irqOut)
  );
endmodule

// File: tb/test_msi_capture_ctrl.sv
module test_msi_capture_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inWrValid = 1'b0;
  logic [63:0] inWrAddr = '0;
  logic [31:0] inWrData = '0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic irqOut;
  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [63:0] TGT = 64'h0000_0001_0000_1000;

  always #4 clk = ~clk;

  msi_capture_ctrl i_msi_capture_ctrl (
    .clk(clk), .rstN(rstN),
    .inWrValid(inWrValid), .inWrAddr(inWrAddr), .inWrData(inWrData),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic regWr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic sendMsg(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    inWrValid = 1'b1; inWrAddr = a; inWrData = d;
    @(negedge clk);
    inWrValid = 1'b0;
  endtask

  task automatic expStatus(input string req, input logic [31:0] exp);
    logic [31:0] d;
    regRd(3'd0, d);
    chk(req, d, exp);
  endtask

  task automatic testReset();
    logic [31:0] d;
    expStatus("R1 status", 32'h0);
    regRd(3'd2, d); chk("R1 mask@2", d, 32'hffffffff);
    regRd(3'd3, d); chk("R1 mask@3", d, 32'hffffffff);
    regRd(3'd4, d); chk("R1 tgtLo", d, 32'h0);
    regRd(3'd5, d); chk("R1 tgtHi", d, 32'h0);
    regRd(3'd6, d); chk("R1 dcfg", d, 32'hffe06540);
    chk("R1 irq", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testDisabled();
    logic [31:0] d;
    regWr(3'd5, TGT[63:32]);
    regWr(3'd4, TGT[31:0]);
    sendMsg(TGT, 32'h6543);
    expStatus("R3 disabled no capture", 32'h0);
    regWr(3'd4, TGT[31:0] | 32'h1);
    regRd(3'd4, d); chk("R10 tgtLo readback", d, 32'h0000_1001);
  endtask

  task automatic testCapture();
    sendMsg(TGT, 32'h6543);
    expStatus("R2 capture vec3", 32'h0000_0008);
    chk("R8 masked no irq", {31'b0, irqOut}, 32'h0);
    sendMsg(TGT | 64'h3, 32'h655f);
    expStatus("R4 low addr bits ignored vec31", 32'h8000_0008);
  endtask

  task automatic testReject();
    sendMsg(TGT | 64'h4, 32'h6541);
    expStatus("R4 addr bit2 mismatch", 32'h8000_0008);
    sendMsg({32'h0, TGT[31:0]}, 32'h6541);
    expStatus("R4 high word mismatch", 32'h8000_0008);
    sendMsg(TGT, 32'h6641);
    expStatus("R5 pattern mismatch", 32'h8000_0008);
    sendMsg(TGT, 32'h7541);
    expStatus("R5 pattern top bit", 32'h8000_0008);
    sendMsg(TGT, 32'habcd_6541);
    expStatus("R5 upper data ignored vec1", 32'h8000_000a);
  endtask

  task automatic testMask();
    logic [31:0] d;
    regWr(3'd3, 32'h0000_0002);
    regRd(3'd2, d); chk("R7 mask clr", d, 32'hffff_fffd);
    chk("R8 irq unmasked", {31'b0, irqOut}, 32'h1);
    regWr(3'd2, 32'h0000_0002);
    regRd(3'd3, d); chk("R7 mask set", d, 32'hffff_ffff);
    chk("R8 irq remasked", {31'b0, irqOut}, 32'h0);
    regWr(3'd3, 32'hffff_ffff);
    regRd(3'd2, d); chk("R7 mask clr all", d, 32'h0);
    chk("R8 irq all open", {31'b0, irqOut}, 32'h1);
  endtask

  task automatic testClear();
    logic [31:0] d;
    regWr(3'd1, 32'h0000_0008);
    expStatus("R6 clear bit3", 32'h8000_0002);
    regWr(3'd1, 32'h0);
    expStatus("R6 clear zero", 32'h8000_0002);
    regRd(3'd1, d); chk("R6 clear reads 0", d, 32'h0);
    regWr(3'd1, 32'hffff_ffff);
    expStatus("R6 clear all", 32'h0);
    chk("R8 irq after clear", {31'b0, irqOut}, 32'h0);
  endtask

  task automatic testCollision();
    @(negedge clk);
    inWrValid = 1'b1; inWrAddr = TGT; inWrData = 32'h6545;
    regWrEn = 1'b1; regAddr = 3'd1; regWrData = 32'h0000_0021;
    @(negedge clk);
    inWrValid = 1'b0; regWrEn = 1'b0;
    expStatus("R9 capture beats clear", 32'h0000_0020);
    chk("R9 irq", {31'b0, irqOut}, 32'h1);
    regWr(3'd1, 32'h0000_0020);
    expStatus("R9 later clear", 32'h0);
  endtask

  task automatic testMap();
    logic [31:0] d;
    regWr(3'd0, 32'hffff_ffff);
    expStatus("R10 status write ignored", 32'h0);
    regRd(3'd7, d); chk("R10 offset7 zero", d, 32'h0);
    regWr(3'd6, 32'hff00_1200);
    regRd(3'd6, d); chk("R10 dcfg readback", d, 32'hff00_1200);
    sendMsg(TGT, 32'h0000_1234);
    expStatus("R2 new pattern vec20", 32'h0010_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog all-reqs act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testCapture();
    testReject();
    testMask();
    testClear();
    testCollision();
    testMap();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule